// File: doc/BRIEF.md
# 64B/66B Transmit Block Encoder

This block turns eight octets of transmit-side media-independent-interface traffic, each with its own control flag, into one 66-bit line block. The block has a 2-bit sync header and a 64-bit payload. The eight octets are two consecutive 32-bit transfers laid side by side, with the earlier transfer in the low half. Lane `i` is `in_data[8i+7:8i]`, and its flag is `in_ctrl[i]`. Blocks made only of data pass through unchanged. A block with at least one control character is recoded into a type byte followed by packed fields: data octets, 7-bit control codes, 4-bit ordered-set codes and padding.

The encoder recognises idle, error, start, terminate and two kinds of ordered set. It checks where each character sits. A start or an ordered set is accepted only in lane 0 or lane 4. A terminate may sit in any lane, but the lanes before it must hold data and the lanes after it must hold idle or error. Any pattern outside the supported shapes becomes an error block. The result is registered once, with a valid flag beside it. Scrambling, gearboxing and decoding are done by other blocks.

Top module: `enc66_encoder`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge, and the encoded word is likewise presented one cycle after it was sampled. While `rst_n` is low, `out_valid`, `out_hdr` and `out_payload` are all zero.
- R2: If all eight control flags are 0, the output header is 2'b01 and the payload equals `in_data` bit for bit.
- R3: If any control flag is 1, the output header is 2'b10 and the type byte `out_payload[7:0]` is one of 0x1E, 0x78, 0x33, 0x4B, 0x2D, 0x55, 0x66, 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF. The recognised control octets are idle 0x07, error 0xFE, start 0xFB, terminate 0xFD, sequence ordered set 0x9C and signal ordered set 0x5C.
- R4: If all eight lanes carry idle or error, the block has type 0x1E. The 7-bit code of lane m sits at `out_payload[8+7m +: 7]`, with idle coded as 0x00 and error as 0x1E.
- R5: A start in lane 0 with data in lanes 1 to 7 gives type 0x78, with `out_payload[63:8]` equal to `in_data[63:8]`.
- R6: A start in lane 4 with data in lanes 5 to 7 gives a payload that carries `in_data[63:40]` in bits 63:40 and zeros in bits 39:36. If lanes 0 to 3 are idle or error, the type is 0x33 and their codes sit at bits 8+7m. If lane 0 is an ordered set and lanes 1 to 3 are data, the type is 0x66, `in_data[31:8]` sits in bits 31:8 and the lane 0 ordered-set code sits in bits 35:32.
- R7: Ordered sets use the ordered-set code 0x0 for 0x9C and 0xF for 0x5C. The supported ordered-set blocks are:
  - type 0x4B: lane 0 is an ordered set, lanes 1 to 3 are data and lanes 4 to 7 are idle or error. The payload is code in 35:32, data in 31:8, control codes at 8+7m.
  - type 0x2D: lanes 0 to 3 are idle or error, lane 4 is an ordered set and lanes 5 to 7 are data. The payload is control codes at 8+7m, code in 39:36, data in 63:40.
  - type 0x55: ordered sets in lanes 0 and 4 with data elsewhere. The payload is lane 0 code in 35:32, lane 4 code in 39:36, data in 31:8 and 63:40.
- R8: A terminate in lane k, with data in every lane below k and idle or error in every lane above k, gives type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0 to 7. Data lane j is at bits 8+8j, the code of lane m > k is at bits 8+7m, and all other payload bits are zero.
- R9: Every other control pattern gives an error block: header 2'b10, type 0x1E and all eight 7-bit codes equal to 0x1E. Such patterns include a start or ordered set outside lanes 0 and 4, an unknown control octet, data after a terminate, two terminates, or a start followed by a control character.
- R10: While `in_valid` is low, `out_hdr` and `out_payload` keep the values they last held, whatever `in_data` and `in_ctrl` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The eight lanes on `in_data`/`in_ctrl` are to be encoded |
| in_data | input | 64 | Eight octets, lane i in bits 8i+7:8i |
| in_ctrl | input | 8 | Per-lane flag, 1 marks a control octet |
| out_valid | output | 1 | Encoded block is present this cycle |
| out_hdr | output | 2 | Sync header, 01 data, 10 control |
| out_payload | output | 64 | Encoded payload, type byte in bits 7:0 |

## Verification
Each input block is encoded within one cycle and then leaves the register, so a wrong lane classification or format choice shows up on the very next valid output. It appears as a wrong type byte or as data and codes at the wrong offsets. A placement check that is too loose or too strict turns a legal block into the error pattern, or the reverse, one cycle after the offending input. A hold or valid path that misbehaves shows in the cycles when `in_valid` is low, as a payload that changes or a valid flag that does not drop.

// File: rtl/enc66_pkg.sv
`timescale 1ns/1ps
package enc66_pkg;

    localparam int LANES   = 8;
    localparam int OCT_W   = 8;
    localparam int CODE_W  = 7;
    localparam int OSET_W  = 4;
    localparam int HDR_W   = 2;
    localparam int PAY_W   = LANES * OCT_W;
    localparam int POS_W   = $clog2(LANES);
    localparam int HALF    = LANES / 2;

    // interface control octets
    localparam logic [OCT_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [OCT_W-1:0] CH_ERROR = 8'hFE;
    localparam logic [OCT_W-1:0] CH_START = 8'hFB;
    localparam logic [OCT_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [OCT_W-1:0] CH_SEQ   = 8'h9C;
    localparam logic [OCT_W-1:0] CH_SIG   = 8'h5C;

    // line codes
    localparam logic [CODE_W-1:0] LC_IDLE  = 7'h00;
    localparam logic [CODE_W-1:0] LC_ERROR = 7'h1E;
    localparam logic [OSET_W-1:0] OC_SEQ   = 4'h0;
    localparam logic [OSET_W-1:0] OC_SIG   = 4'hF;

    localparam logic [HDR_W-1:0] SH_DATA = 2'b01;
    localparam logic [HDR_W-1:0] SH_CTRL = 2'b10;

    localparam logic [OCT_W-1:0] BT_CTRL = 8'h1E;
    localparam logic [OCT_W-1:0] BT_S0   = 8'h78;
    localparam logic [OCT_W-1:0] BT_S4   = 8'h33;
    localparam logic [OCT_W-1:0] BT_O0   = 8'h4B;
    localparam logic [OCT_W-1:0] BT_O4   = 8'h2D;
    localparam logic [OCT_W-1:0] BT_OO   = 8'h55;
    localparam logic [OCT_W-1:0] BT_OS   = 8'h66;

    typedef enum logic [3:0] {
        FMT_DATA,
        FMT_CTRL,
        FMT_S0,
        FMT_S4,
        FMT_O0,
        FMT_O4,
        FMT_OO,
        FMT_OS,
        FMT_TERM,
        FMT_ERR
    } blk_fmt_e;

    typedef struct packed {
        logic              valid;
        logic [HDR_W-1:0]  hdr;
        logic [PAY_W-1:0]  pay;
    } enc_state_t;

    function automatic logic [OCT_W-1:0] term_type(input logic [POS_W-1:0] pos);
        logic [OCT_W-1:0] t;
        case (pos)
            3'd0:    t = 8'h87;
            3'd1:    t = 8'h99;
            3'd2:    t = 8'hAA;
            3'd3:    t = 8'hB4;
            3'd4:    t = 8'hCC;
            3'd5:    t = 8'hD2;
            3'd6:    t = 8'hE1;
            default: t = 8'hFF;
        endcase
        return t;
    endfunction

    function automatic logic [OSET_W-1:0] oset_code(input logic [OCT_W-1:0] oct);
        return (oct == CH_SIG) ? OC_SIG : OC_SEQ;
    endfunction

endpackage

// File: rtl/enc66_lane_class.sv
`timescale 1ns/1ps
module enc66_lane_class
    import enc66_pkg::*;
(
    input  logic              ctrl_i,
    input  logic [OCT_W-1:0]  oct_i,
    output logic              is_data_o,
    output logic              is_ctl_o,
    output logic              is_start_o,
    output logic              is_term_o,
    output logic              is_ord_o,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        is_data_o  = 1'b0;
        is_ctl_o   = 1'b0;
        is_start_o = 1'b0;
        is_term_o  = 1'b0;
        is_ord_o   = 1'b0;
        code_o     = LC_ERROR;
        if (!ctrl_i) begin
            is_data_o = 1'b1;
        end else begin
            case (oct_i)
                CH_IDLE: begin
                    is_ctl_o = 1'b1;
                    code_o   = LC_IDLE;
                end
                CH_ERROR: begin
                    is_ctl_o = 1'b1;
                    code_o   = LC_ERROR;
                end
                CH_START: is_start_o = 1'b1;
                CH_TERM:  is_term_o  = 1'b1;
                CH_SEQ,
                CH_SIG:   is_ord_o   = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/enc66_format_sel.sv
`timescale 1ns/1ps
module enc66_format_sel
    import enc66_pkg::*;
(
    input  logic [LANES-1:0] m_data_i,
    input  logic [LANES-1:0] m_ctl_i,
    input  logic [LANES-1:0] m_start_i,
    input  logic [LANES-1:0] m_term_i,
    input  logic [LANES-1:0] m_ord_i,
    output blk_fmt_e         fmt_o,
    output logic [POS_W-1:0] tpos_o
);

    // lanes where a start or an ordered set may legally sit
    localparam logic [LANES-1:0] ANCHOR = LANES'(1) | (LANES'(1) << HALF);

    logic             misplaced;
    logic             t_found;
    logic [POS_W-1:0] t_pos;
    logic             t_ok;
    logic             lo_data, hi_data, lo_ctl, hi_ctl;

    assign misplaced = |((m_start_i | m_ord_i) & ~ANCHOR);
    assign lo_data   = &m_data_i[HALF-1:1];
    assign hi_data   = &m_data_i[LANES-1:HALF+1];
    assign lo_ctl    = &m_ctl_i[HALF-1:0];
    assign hi_ctl    = &m_ctl_i[LANES-1:HALF];

    // lowest terminate and the shape of the lanes around it
    always_comb begin
        t_found = 1'b0;
        t_pos   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (m_term_i[i] && !t_found) begin
                t_found = 1'b1;
                t_pos   = POS_W'(i);
            end
        end
        t_ok = t_found;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(t_pos)) begin
                t_ok = t_ok & m_data_i[i];
            end else if (i > int'(t_pos)) begin
                t_ok = t_ok & m_ctl_i[i];
            end
        end
    end

    always_comb begin
        tpos_o = t_pos;
        if (misplaced) begin
            fmt_o = FMT_ERR;
        end else if (&m_data_i) begin
            fmt_o = FMT_DATA;
        end else if (&m_ctl_i) begin
            fmt_o = FMT_CTRL;
        end else if (m_start_i[0] && lo_data && m_data_i[HALF] && hi_data) begin
            fmt_o = FMT_S0;
        end else if (lo_ctl && m_start_i[HALF] && hi_data) begin
            fmt_o = FMT_S4;
        end else if (m_ord_i[0] && lo_data && hi_ctl) begin
            fmt_o = FMT_O0;
        end else if (lo_ctl && m_ord_i[HALF] && hi_data) begin
            fmt_o = FMT_O4;
        end else if (m_ord_i[0] && lo_data && m_ord_i[HALF] && hi_data) begin
            fmt_o = FMT_OO;
        end else if (m_ord_i[0] && lo_data && m_start_i[HALF] && hi_data) begin
            fmt_o = FMT_OS;
        end else if (t_ok) begin
            fmt_o = FMT_TERM;
        end else begin
            fmt_o = FMT_ERR;
        end
    end

endmodule

// File: rtl/enc66_payload.sv
`timescale 1ns/1ps
module enc66_payload
    import enc66_pkg::*;
(
    input  blk_fmt_e                 fmt_i,
    input  logic [POS_W-1:0]         tpos_i,
    input  logic [PAY_W-1:0]         data_i,
    input  logic [LANES*CODE_W-1:0]  codes_i,
    output logic [HDR_W-1:0]         hdr_o,
    output logic [PAY_W-1:0]         pay_o
);

    localparam int HI_LO = HALF * OCT_W;          // first bit of lane HALF
    localparam int OC_LO = HALF * OCT_W;          // ordered-set code of lane 0
    localparam int OC_HI = HALF * OCT_W + OSET_W; // ordered-set code of lane HALF
    localparam int CT_W  = HALF * CODE_W;         // four packed control codes

    logic [OSET_W-1:0] oc_lo, oc_hi;
    logic [PAY_W-1:0]  err_pay;

    assign oc_lo   = oset_code(data_i[OCT_W-1:0]);
    assign oc_hi   = oset_code(data_i[HI_LO +: OCT_W]);
    assign err_pay = {{LANES{LC_ERROR}}, BT_CTRL};

    always_comb begin
        hdr_o = SH_CTRL;
        pay_o = '0;
        unique case (fmt_i)
            FMT_DATA: begin
                hdr_o = SH_DATA;
                pay_o = data_i;
            end
            FMT_CTRL: pay_o = {codes_i, BT_CTRL};
            FMT_S0:   pay_o = {data_i[PAY_W-1:OCT_W], BT_S0};
            FMT_S4: begin
                pay_o[OCT_W-1:0]           = BT_S4;
                pay_o[OCT_W +: CT_W]       = codes_i[CT_W-1:0];
                pay_o[PAY_W-1:HI_LO+OCT_W] = data_i[PAY_W-1:HI_LO+OCT_W];
            end
            FMT_O0: begin
                pay_o[OCT_W-1:0]           = BT_O0;
                pay_o[HI_LO-1:OCT_W]       = data_i[HI_LO-1:OCT_W];
                pay_o[OC_LO +: OSET_W]     = oc_lo;
                pay_o[PAY_W-1:OC_HI]       = codes_i[LANES*CODE_W-1:CT_W];
            end
            FMT_O4: begin
                pay_o[OCT_W-1:0]           = BT_O4;
                pay_o[OCT_W +: CT_W]       = codes_i[CT_W-1:0];
                pay_o[OC_HI +: OSET_W]     = oc_hi;
                pay_o[PAY_W-1:HI_LO+OCT_W] = data_i[PAY_W-1:HI_LO+OCT_W];
            end
            FMT_OO: begin
                pay_o[OCT_W-1:0]           = BT_OO;
                pay_o[HI_LO-1:OCT_W]       = data_i[HI_LO-1:OCT_W];
                pay_o[OC_LO +: OSET_W]     = oc_lo;
                pay_o[OC_HI +: OSET_W]     = oc_hi;
                pay_o[PAY_W-1:HI_LO+OCT_W] = data_i[PAY_W-1:HI_LO+OCT_W];
            end
            FMT_OS: begin
                pay_o[OCT_W-1:0]           = BT_OS;
                pay_o[HI_LO-1:OCT_W]       = data_i[HI_LO-1:OCT_W];
                pay_o[OC_LO +: OSET_W]     = oc_lo;
                pay_o[PAY_W-1:HI_LO+OCT_W] = data_i[PAY_W-1:HI_LO+OCT_W];
            end
            FMT_TERM: begin
                pay_o[OCT_W-1:0] = term_type(tpos_i);
                for (int j = 0; j < LANES; j++) begin
                    if (j < int'(tpos_i)) begin
                        pay_o[OCT_W + OCT_W*j +: OCT_W] = data_i[OCT_W*j +: OCT_W];
                    end else if (j > int'(tpos_i)) begin
                        pay_o[OCT_W + CODE_W*j +: CODE_W] = codes_i[CODE_W*j +: CODE_W];
                    end
                end
            end
            default: pay_o = err_pay;
        endcase
    end

endmodule

// File: rtl/enc66_encoder.sv
`timescale 1ns/1ps
module enc66_encoder
    import enc66_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PAY_W-1:0]  in_data,
    input  logic [LANES-1:0]  in_ctrl,
    output logic              out_valid,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [PAY_W-1:0]  out_payload
);

    logic [LANES-1:0]         m_data, m_ctl, m_start, m_term, m_ord;
    logic [LANES*CODE_W-1:0]  codes;
    blk_fmt_e                 fmt;
    logic [POS_W-1:0]         tpos;
    logic [HDR_W-1:0]         enc_hdr;
    logic [PAY_W-1:0]         enc_pay;
    enc_state_t               st_d, st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        enc66_lane_class u_class (
            .ctrl_i     (in_ctrl[g]),
            .oct_i      (in_data[OCT_W*g +: OCT_W]),
            .is_data_o  (m_data[g]),
            .is_ctl_o   (m_ctl[g]),
            .is_start_o (m_start[g]),
            .is_term_o  (m_term[g]),
            .is_ord_o   (m_ord[g]),
            .code_o     (codes[CODE_W*g +: CODE_W])
        );
    end

    enc66_format_sel u_sel (
        .m_data_i  (m_data),
        .m_ctl_i   (m_ctl),
        .m_start_i (m_start),
        .m_term_i  (m_term),
        .m_ord_i   (m_ord),
        .fmt_o     (fmt),
        .tpos_o    (tpos)
    );

    enc66_payload u_pay (
        .fmt_i   (fmt),
        .tpos_i  (tpos),
        .data_i  (in_data),
        .codes_i (codes),
        .hdr_o   (enc_hdr),
        .pay_o   (enc_pay)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.hdr = enc_hdr;
            st_d.pay = enc_pay;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_hdr     = st_q.hdr;
    assign out_payload = st_q.pay;

endmodule

// File: rtl/enc66_checks.sv
`timescale 1ns/1ps
module enc66_checks
    import enc66_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PAY_W-1:0]  in_data,
    input logic [LANES-1:0]  in_ctrl,
    input logic              out_valid,
    input logic [HDR_W-1:0]  out_hdr,
    input logic [PAY_W-1:0]  out_payload
);

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl == '0) |=> (out_hdr == SH_DATA && out_payload == $past(in_data)));

    assert_ctrl_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl != '0) |=> out_hdr == SH_CTRL);

    assert_type_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hdr == SH_CTRL) |->
            (out_payload[7:0] inside {8'h1E, 8'h78, 8'h33, 8'h4B, 8'h2D, 8'h55, 8'h66,
                                      8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF}));

    assert_start0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl == 8'h01 && in_data[7:0] == CH_START) |=>
            (out_payload[7:0] == BT_S0 && out_payload[63:8] == $past(in_data[63:8])));

    assert_bad_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl[1:0] == 2'b11 && in_data[7:0] == CH_START) |=>
            (out_payload == {{LANES{LC_ERROR}}, BT_CTRL}));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_payload) && $stable(out_hdr)));

endmodule

bind enc66_encoder enc66_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ctrl     (in_ctrl),
    .out_valid   (out_valid),
    .out_hdr     (out_hdr),
    .out_payload (out_payload)
);

// File: tb/tb_enc66_encoder.sv
`timescale 1ns/1ps
module tb_enc66_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        out_valid;
    logic [1:0]  out_hdr;
    logic [63:0] out_payload;

    enc66_encoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_hdr(out_hdr),
        .out_payload(out_payload)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [1:0]  h;
        logic [63:0] p;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    localparam logic [63:0] ERR_BLK = {{8{7'h1E}}, 8'h1E};
    localparam logic [7:0]  TT [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] d, input logic [7:0] c,
                        input logic [1:0] h, input logic [63:0] p, input string tag);
        exp_t e;
        e.h = h; e.p = p; e.tag = tag;
        exp_q.push_back(e);
        in_valid = 1'b1;
        in_data  = d;
        in_ctrl  = c;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0;
        in_data  = 64'hDEAD_BEEF_0BAD_F00D;
        in_ctrl  = 8'hA5;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    logic        iv_cap = 1'b0;
    logic        have_last = 1'b0;
    logic [65:0] last_out = '0;

    always @(posedge clk) iv_cap <= rst_n ? in_valid : 1'b0;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            check(out_valid == iv_cap, "R1", "valid latency", 66'(out_valid), 66'(iv_cap));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected block", {out_hdr, out_payload}, '0);
                end else begin
                    e = exp_q.pop_front();
                    check({out_hdr, out_payload} === {e.h, e.p}, e.tag, "block",
                          {out_hdr, out_payload}, {e.h, e.p});
                end
                last_out  = {out_hdr, out_payload};
                have_last = 1'b1;
            end else if (have_last) begin
                check({out_hdr, out_payload} === last_out, "R10", "hold",
                      {out_hdr, out_payload}, last_out);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] p;
        logic [7:0]  c;

        repeat (3) @(negedge clk);
        check({out_valid, out_hdr, out_payload} == '0, "R1", "reset state",
              {out_hdr, out_payload}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all-data blocks pass through
        push(64'h0123_4567_89AB_CDEF, 8'h00, 2'b01, 64'h0123_4567_89AB_CDEF, "R2");
        push(64'hFBFD_0707_FE9C_5CFB, 8'h00, 2'b01, 64'hFBFD_0707_FE9C_5CFB, "R2");
        push(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, "R2");

        // R4: all idle, then idle mixed with error in lanes 2 and 5
        push({8{8'h07}}, 8'hFF, 2'b10, {56'h0, 8'h1E}, "R4");
        d = {8'h07, 8'h07, 8'hFE, 8'h07, 8'h07, 8'hFE, 8'h07, 8'h07};
        p = {56'h0, 8'h1E};
        p[8+7*2 +: 7] = 7'h1E;
        p[8+7*5 +: 7] = 7'h1E;
        push(d, 8'hFF, 2'b10, p, "R4");

        gap(2);

        // R5: start in lane 0
        d = {56'h11_2233_4455_6677, 8'hFB};
        push(d, 8'h01, 2'b10, {d[63:8], 8'h78}, "R5");

        // R6: start in lane 4 after idles, then after an ordered set
        d = {24'hA1A2A3, 8'hFB, 8'h07, 8'hFE, 8'h07, 8'h07};
        p = {d[63:40], 4'h0, 28'h0, 8'h33};
        p[8+7*2 +: 7] = 7'h1E;
        push(d, 8'h1F, 2'b10, p, "R6");
        d = {24'hB1B2B3, 8'hFB, 24'hC1C2C3, 8'h5C};
        push(d, 8'h11, 2'b10, {d[63:40], 4'h0, 4'hF, d[31:8], 8'h66}, "R6");

        // R7: ordered-set blocks
        d = {8'h07, 8'h07, 8'h07, 8'h07, 24'h445566, 8'h9C};
        push(d, 8'hF1, 2'b10, {28'h0, 4'h0, d[31:8], 8'h4B}, "R7");
        d = {8'hFE, 8'h07, 8'h07, 8'h07, 24'h778899, 8'h5C};
        push(d, 8'hF1, 2'b10, {7'h1E, 21'h0, 4'hF, d[31:8], 8'h4B}, "R7");
        d = {24'hD1D2D3, 8'h5C, 8'h07, 8'h07, 8'h07, 8'h07};
        push(d, 8'h1F, 2'b10, {d[63:40], 4'hF, 28'h0, 8'h2D}, "R7");
        d = {24'hE1E2E3, 8'h5C, 24'hF1F2F3, 8'h9C};
        push(d, 8'h11, 2'b10, {d[63:40], 4'hF, 4'h0, d[31:8], 8'h55}, "R7");

        gap(3);

        // R8: terminate in every lane; lane 7 carries error when after the terminate
        for (int k = 0; k < 8; k++) begin
            d = '0;
            p = '0;
            p[7:0] = TT[k];
            for (int j = 0; j < 8; j++) begin
                if (j < k) begin
                    d[8*j +: 8] = 8'(8'h20 + 8*k + j);
                    p[8 + 8*j +: 8] = d[8*j +: 8];
                end else if (j == k) begin
                    d[8*j +: 8] = 8'hFD;
                end else if (j == 7) begin
                    d[8*j +: 8] = 8'hFE;
                    p[8 + 7*j +: 7] = 7'h1E;
                end else begin
                    d[8*j +: 8] = 8'h07;
                end
            end
            c = 8'hFF << k;
            push(d, c, 2'b10, p, "R8");
        end

        // R9: illegal placements and characters
        d = {32'h1111_1111, 8'h22, 8'hFB, 16'h3333};
        push(d, 8'h04, 2'b10, ERR_BLK, "R9");
        d = {8'h07, 8'h07, 8'h07, 8'h07, 16'h4444, 8'h9C, 8'h55};
        push(d, 8'hF2, 2'b10, ERR_BLK, "R9");
        push({8{8'hAB}}, 8'hFF, 2'b10, ERR_BLK, "R9");
        d = {8'h07, 8'h66, 8'h07, 8'hFD, 32'h0};
        push(d, 8'hB0, 2'b10, ERR_BLK, "R9");
        d = {8'h07, 8'hFD, 8'h07, 8'hFD, 32'h0};
        push(d, 8'hF0, 2'b10, ERR_BLK, "R9");
        d = {48'h0, 8'h07, 8'hFB};
        push(d, 8'h03, 2'b10, ERR_BLK, "R9");
        d = {24'h0, 8'hFB, 8'h07, 8'h07, 8'h07, 8'h07};
        push(d, 8'h3F, 2'b10, ERR_BLK, "R9");

        // R10: a gap with garbage on the inputs, then data again
        gap(4);
        push(64'h5555_AAAA_5555_AAAA, 8'h00, 2'b01, 64'h5555_AAAA_5555_AAAA, "R2");
        gap(3);

        check(exp_q.size() == 0, "R1", "blocks left undelivered",
              66'(exp_q.size()), '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule